// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Unlock

This block is a watchdog timer that sits behind a small byte-addressed write port. Once enabled it counts down a first interval; if software does not service it in time, it raises a timeout flag, optionally flips an output pin, and then starts a second interval. If that second interval also runs out, it issues a one-cycle system reset request, with a level that says whether a warm or a cold reset is wanted. Software services the timer by issuing a reload command, which restarts the first interval.

The two interval lengths and the reload/clear command are protected. A write to them only takes effect when it comes straight after a two-write key pattern on the key address. A lock bit can be set together with the enable bit. After that, the timer cannot be stopped and the control settings are frozen until the block is reset.

Each preload is PRE_W bits wide. In coarse mode a preload fills the top of a (PRE_W+FRAC_W)-bit down counter, so an interval lasts (P+1)·2^FRAC_W clocks. The defaults (20 and 15) reach 1 s to 600 s at a 33 MHz count clock. In fine mode an interval lasts P+1 clocks. The write-data bus is PRE_W bits wide, and PRE_W must be at least 8.

Top module: `twostage_wdog`

Register addresses and fields used below (byte registers take their value in `wr_data[7:0]`):
- Address 0x00 holds the first-interval preload and address 0x04 holds the second-interval preload. Both are protected.
- Address 0x0C is the key address.
- Address 0x0D is the protected command register: bit 0 reloads the timer and bit 1 clears the timeout flag.
- Address 0x10 is the control register: bit 2 selects fine mode, bit 3 selects a warm reset, bit 4 enables the reset request, and bit 5 suppresses the pin toggle.
- Address 0x18 is the lock/enable register: bit 1 enables counting and bit 0 locks.

Stage machine states, and the transitions between them:
- IDLE moves to FIRST on the cycle after the timer is enabled.
- FIRST moves to SECOND when the first interval expires.
- SECOND moves to HALT when the second interval expires.
- A reload command moves the timer from FIRST, SECOND or HALT back to FIRST.
- Disabling the timer returns it to IDLE from any state.

Key machine states, and the transitions between them:
- CLOSED moves to HALF on the first key value.
- HALF moves to OPEN on the second key value.
- Any other write returns the key machine to CLOSED.
- A write of the first key value moves it to HALF from any state.

## Requirements
- R1: After reset, tout_flag, toggle_out, rst_req and rst_warm are 0, all registers are 0, and no key is open.
- R2: A write to 0x00, 0x04 or 0x0D is accepted only when the two writes just before it were 0x80 to 0x0C and then 0x86 to 0x0C. Each such write consumes the key.
- R3: A protected write is ignored if the key values came in the wrong order, or if any other write came between the key and the protected write.
- R4: In coarse mode, tout_flag rises (P1+1)·2^FRAC_W+1 clock edges after the edge that wrote enable (bit 1 of 0x18).
- R5: When the first interval expires, toggle_out flips, unless control bit 5 is set.
- R6: The second interval lasts (P2+1)·2^FRAC_W clocks. When it expires, rst_req is high for exactly one cycle if control bit 4 is set. rst_warm follows control bit 3.
- R7: With control bit 2 set, an interval lasts P+1 clocks.
- R8: A reload (bit 0 of 0x0D) from any running state, including after the second interval has expired, restarts the first interval with its full length.
- R9: Writing 1 to bit 1 of 0x0D clears tout_flag. When expiry and clear happen in the same cycle, expiry wins.
- R10: Once bit 0 of 0x18 is set, it stays set until reset, and further writes to 0x18 and 0x10 are ignored, so the timer cannot be disabled.
- R11: Writing 0 to bit 1 of 0x18 while unlocked stops the timer. No rst_req follows, and tout_flag and toggle_out hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 5 | Byte address of the write |
| wr_data | input | PRE_W | Write data; byte registers use bits 7:0 |
| tout_flag | output | 1 | First-interval timeout flag |
| toggle_out | output | 1 | Pin that flips at each first-interval expiry |
| rst_req | output | 1 | One-cycle system reset request |
| rst_warm | output | 1 | 1 requests a warm reset, 0 a cold reset |

## Verification
The bench builds the block with PRE_W = 8 and FRAC_W = 3. A coarse interval then lasts only 8·(P+1) clocks, so both stages, the reset pulse and a reload after expiry all fit in a few hundred cycles. The bench exercises both counting modes. It compares a behavioural model that counts remaining cycles against the outputs on every clock, and it adds explicit edge-exact checks around each expiry.

// File: rtl/twostage_wdog_pkg.sv
package twostage_wdog_pkg;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] ADDR_PRE1 = 5'h00;
    localparam logic [ADDR_W-1:0] ADDR_PRE2 = 5'h04;
    localparam logic [ADDR_W-1:0] ADDR_KEY  = 5'h0C;
    localparam logic [ADDR_W-1:0] ADDR_CMD  = 5'h0D;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 5'h10;
    localparam logic [ADDR_W-1:0] ADDR_LOCK = 5'h18;
    localparam logic [7:0] KEY_FIRST  = 8'h80;
    localparam logic [7:0] KEY_SECOND = 8'h86;

    typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND, ST_HALT} stage_e;
    typedef enum logic [1:0] {UL_CLOSED, UL_HALF, UL_OPEN} key_e;

    // control fields in bit order 5..2
    typedef struct packed {
        logic toggle_off;
        logic reset_on;
        logic warm;
        logic fine;
    } ctrl_t;
endpackage

// File: rtl/twostage_wdog_key.sv
module twostage_wdog_key
    import twostage_wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_byte,
    output logic              grant
);
    key_e state, nxt;
    logic is_first, is_second;

    assign is_first  = (wr_addr == ADDR_KEY) && (wr_byte == KEY_FIRST);
    assign is_second = (wr_addr == ADDR_KEY) && (wr_byte == KEY_SECOND);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= UL_CLOSED;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (wr_en) begin
            unique case (state)
                UL_CLOSED: nxt = is_first ? UL_HALF : UL_CLOSED;
                UL_HALF:   nxt = is_second ? UL_OPEN : (is_first ? UL_HALF : UL_CLOSED);
                UL_OPEN:   nxt = is_first ? UL_HALF : UL_CLOSED;
                default:   nxt = UL_CLOSED;
            endcase
        end
    end

    assign grant = (state == UL_OPEN);

    AST_GRANT_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> $past(wr_en && wr_addr == ADDR_KEY && wr_byte == KEY_SECOND)); // R2
    AST_GRANT_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && wr_en) |=> !grant); // R2
endmodule

// File: rtl/twostage_wdog_cfg.sv
module twostage_wdog_cfg
    import twostage_wdog_pkg::*;
#(
    parameter int PRE_W = 20
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PRE_W-1:0]  wr_data,
    input  logic              grant,
    output logic [PRE_W-1:0]  pre1,
    output logic [PRE_W-1:0]  pre2,
    output ctrl_t             ctrl,
    output logic              en,
    output logic              reload_cmd,
    output logic              clear_cmd
);
    logic lock;
    logic prot_ok;

    assign prot_ok    = wr_en && grant;
    assign reload_cmd = prot_ok && (wr_addr == ADDR_CMD) && wr_data[0];
    assign clear_cmd  = prot_ok && (wr_addr == ADDR_CMD) && wr_data[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre1 <= '0;
            pre2 <= '0;
            ctrl <= '0;
            en   <= 1'b0;
            lock <= 1'b0;
        end else begin
            if (prot_ok && wr_addr == ADDR_PRE1) pre1 <= wr_data;
            if (prot_ok && wr_addr == ADDR_PRE2) pre2 <= wr_data;
            if (wr_en && wr_addr == ADDR_CTRL && !lock) ctrl <= ctrl_t'(wr_data[5:2]);
            if (wr_en && wr_addr == ADDR_LOCK && !lock) begin
                en   <= wr_data[1];
                lock <= wr_data[0];
            end
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock); // R10
    AST_LOCKED_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && en) |=> en); // R10
    AST_LOCKED_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(ctrl)); // R10
endmodule

// File: rtl/twostage_wdog_timer.sv
module twostage_wdog_timer
    import twostage_wdog_pkg::*;
#(
    parameter int PRE_W  = 20,
    parameter int FRAC_W = 15
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] pre1,
    input  logic [PRE_W-1:0] pre2,
    input  logic             fine,
    input  logic             toggle_off,
    input  logic             reset_on,
    input  logic             reload_cmd,
    input  logic             clear_cmd,
    output logic             tout_flag,
    output logic             toggle_out,
    output logic             rst_req
);
    localparam int CNT_W = PRE_W + FRAC_W;

    stage_e          state, nstate;
    logic [CNT_W-1:0] cnt, ncnt;
    logic            exp1, exp2;

    function automatic logic [CNT_W-1:0] load_of(input logic [PRE_W-1:0] p, input logic f);
        if (f) return CNT_W'(p);
        else   return {p, {FRAC_W{1'b1}}};
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nstate;
            cnt   <= ncnt;
        end
    end

    always_comb begin
        nstate = state;
        ncnt   = cnt;
        exp1   = 1'b0;
        exp2   = 1'b0;
        unique case (state)
            ST_IDLE: if (en) begin
                nstate = ST_FIRST;
                ncnt   = load_of(pre1, fine);
            end
            ST_FIRST: if (cnt == '0) begin
                nstate = ST_SECOND;
                ncnt   = load_of(pre2, fine);
                exp1   = 1'b1;
            end else ncnt = cnt - 1'b1;
            ST_SECOND: if (cnt == '0) begin
                nstate = ST_HALT;
                exp2   = 1'b1;
            end else ncnt = cnt - 1'b1;
            ST_HALT: ;
            default: nstate = ST_IDLE;
        endcase
        if (state != ST_IDLE && reload_cmd) begin
            nstate = ST_FIRST;
            ncnt   = load_of(pre1, fine);
            exp1   = 1'b0;
            exp2   = 1'b0;
        end
        if (!en) begin
            nstate = ST_IDLE;
            exp1   = 1'b0;
            exp2   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tout_flag  <= 1'b0;
            toggle_out <= 1'b0;
            rst_req    <= 1'b0;
        end else begin
            if (exp1)           tout_flag <= 1'b1;
            else if (clear_cmd) tout_flag <= 1'b0;
            if (exp1 && !toggle_off) toggle_out <= ~toggle_out;
            rst_req <= exp2 && reset_on;
        end
    end

    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R6
    AST_FLAG_ON_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SECOND && $past(state) == ST_FIRST) |-> tout_flag); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> !rst_req); // R11
    AST_IDLE_HOLDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> $stable(toggle_out)); // R11
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
    import twostage_wdog_pkg::*;
#(
    parameter int PRE_W  = 20,
    parameter int FRAC_W = 15
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [4:0]       wr_addr,
    input  logic [PRE_W-1:0] wr_data,
    output logic             tout_flag,
    output logic             toggle_out,
    output logic             rst_req,
    output logic             rst_warm
);
    logic             grant, en, reload_cmd, clear_cmd;
    logic [PRE_W-1:0] pre1, pre2;
    ctrl_t            ctrl;

    twostage_wdog_key u_key (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_byte(wr_data[7:0]), .grant(grant)
    );

    twostage_wdog_cfg #(.PRE_W(PRE_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .grant(grant), .pre1(pre1), .pre2(pre2),
        .ctrl(ctrl), .en(en), .reload_cmd(reload_cmd), .clear_cmd(clear_cmd)
    );

    twostage_wdog_timer #(.PRE_W(PRE_W), .FRAC_W(FRAC_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(en), .pre1(pre1), .pre2(pre2),
        .fine(ctrl.fine), .toggle_off(ctrl.toggle_off), .reset_on(ctrl.reset_on),
        .reload_cmd(reload_cmd), .clear_cmd(clear_cmd),
        .tout_flag(tout_flag), .toggle_out(toggle_out), .rst_req(rst_req)
    );

    assign rst_warm = ctrl.warm;

    AST_RESET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ctrl.reset_on || $past(ctrl.reset_on)); // R6
endmodule

// File: tb/twostage_wdog_test.sv
`timescale 1ns/1ps
module twostage_wdog_test;
    localparam int PRE_W  = 8;
    localparam int FRAC_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [4:0]       wr_addr = '0;
    logic [PRE_W-1:0] wr_data = '0;
    logic             tout_flag, toggle_out, rst_req, rst_warm;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    twostage_wdog #(.PRE_W(PRE_W), .FRAC_W(FRAC_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tout_flag(tout_flag), .toggle_out(toggle_out), .rst_req(rst_req), .rst_warm(rst_warm)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_p1, m_p2, m_en, m_lock, m_fine, m_warm, m_ron, m_toff;
    int  m_key;     // 0 none, 1 first key seen, 2 open
    int  m_stage;   // 0 idle, 1 first, 2 second, 3 halted
    int  m_left;    // cycles left in the current interval
    int  m_flag, m_pin, m_rst;
    int  t_reload, t_clear, t_e1, t_e2, t_stage, t_left, t_key;

    function automatic int span(input int p, input int f);
        return f ? (p + 1) : ((p + 1) << FRAC_W);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_p1 = 0; m_p2 = 0; m_en = 0; m_lock = 0; m_fine = 0; m_warm = 0;
            m_ron = 0; m_toff = 0; m_key = 0; m_stage = 0; m_left = 0;
            m_flag = 0; m_pin = 0; m_rst = 0;
        end else begin
            t_reload = 0; t_clear = 0; t_e1 = 0; t_e2 = 0;
            t_stage = m_stage; t_left = m_left;
            // timer, using the register values held before this edge
            if (m_stage == 0) begin
                if (m_en) begin t_stage = 1; t_left = span(m_p1, m_fine); end
            end else if (m_stage == 1) begin
                if (m_left == 1) begin t_e1 = 1; t_stage = 2; t_left = span(m_p2, m_fine); end
                else t_left = m_left - 1;
            end else if (m_stage == 2) begin
                if (m_left == 1) begin t_e2 = 1; t_stage = 3; end
                else t_left = m_left - 1;
            end
            if (wr_en && m_key == 2 && wr_addr == 5'h0D) begin
                t_reload = int'(wr_data[0]);
                t_clear  = int'(wr_data[1]);
            end
            if (m_stage != 0 && t_reload == 1) begin
                t_stage = 1; t_left = span(m_p1, m_fine); t_e1 = 0; t_e2 = 0;
            end
            if (m_en == 0) begin t_stage = 0; t_e1 = 0; t_e2 = 0; end
            if (t_e1 == 1) m_flag = 1; else if (t_clear == 1) m_flag = 0;
            if (t_e1 == 1 && m_toff == 0) m_pin = 1 - m_pin;
            m_rst = (t_e2 == 1 && m_ron == 1) ? 1 : 0;
            m_stage = t_stage; m_left = t_left;
            // register writes
            t_key = 0;
            if (wr_en) begin
                if (m_key == 2 && wr_addr == 5'h00) m_p1 = int'(wr_data);
                if (m_key == 2 && wr_addr == 5'h04) m_p2 = int'(wr_data);
                if (wr_addr == 5'h10 && m_lock == 0) begin
                    m_fine = int'(wr_data[2]); m_warm = int'(wr_data[3]);
                    m_ron  = int'(wr_data[4]); m_toff = int'(wr_data[5]);
                end
                if (wr_addr == 5'h18 && m_lock == 0) begin
                    m_en = int'(wr_data[1]); m_lock = int'(wr_data[0]);
                end
                if (wr_addr == 5'h0C && wr_data == 8'h80) t_key = 1;
                else if (wr_addr == 5'h0C && wr_data == 8'h86 && m_key == 1) t_key = 2;
                m_key = t_key;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 flag vs model", int'(tout_flag), m_flag);
            chk("R5 pin vs model", int'(toggle_out), m_pin);
            chk("R6 reset request vs model", int'(rst_req), m_rst);
            chk("R6 warm select vs model", int'(rst_warm), m_warm);
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired: actual %0d expected below 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [PRE_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic key();
        wr(5'h0C, 8'h80);
        wr(5'h0C, 8'h86);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 flag after reset", int'(tout_flag), 0);
        chk("R1 pin after reset", int'(toggle_out), 0);
        chk("R1 reset request after reset", int'(rst_req), 0);
        chk("R1 warm after reset", int'(rst_warm), 0);

        wr(5'h10, 8'h18);                 // reset enable + warm
        chk("R6 warm select follows control", int'(rst_warm), 1);
        key(); wr(5'h00, 8'd2);            // R2 accepted: 24 clocks
        key(); wr(5'h04, 8'd1);            // R2 accepted: 16 clocks
        wr(5'h0C, 8'h86); wr(5'h0C, 8'h80); wr(5'h00, 8'd9);   // R3 wrong order
        key(); wr(5'h10, 8'h18); wr(5'h04, 8'd7);              // R3 interrupted key

        wr(5'h18, 8'h02);                  // enable
        repeat (24) @(negedge clk);
        chk("R3 R4 flag still low before first expiry", int'(tout_flag), 0);
        @(negedge clk);
        chk("R2 R4 flag at first expiry", int'(tout_flag), 1);
        chk("R5 pin toggled", int'(toggle_out), 1);
        repeat (15) @(negedge clk);
        chk("R3 R6 no reset before second expiry", int'(rst_req), 0);
        @(negedge clk);
        chk("R6 reset request at second expiry", int'(rst_req), 1);
        @(negedge clk);
        chk("R6 reset request lasts one cycle", int'(rst_req), 0);

        key(); wr(5'h0D, 8'h02);
        chk("R9 flag cleared", int'(tout_flag), 0);
        key(); wr(5'h0D, 8'h01);           // reload from halted
        repeat (23) @(negedge clk);
        chk("R8 flag low before reloaded expiry", int'(tout_flag), 0);
        @(negedge clk);
        chk("R8 flag at reloaded expiry", int'(tout_flag), 1);
        chk("R5 pin toggled back", int'(toggle_out), 0);

        wr(5'h18, 8'h00);                  // disable during second interval
        repeat (40) @(negedge clk);
        chk("R11 no reset after disable", int'(rst_req), 0);
        chk("R11 flag held after disable", int'(tout_flag), 1);

        key(); wr(5'h0D, 8'h02);
        wr(5'h10, 8'h34);                  // fine, reset enable, no toggle, cold
        chk("R6 cold select", int'(rst_warm), 0);
        wr(5'h18, 8'h02);
        repeat (3) @(negedge clk);
        chk("R7 flag low before fine expiry", int'(tout_flag), 0);
        @(negedge clk);
        chk("R7 flag at fine expiry", int'(tout_flag), 1);
        chk("R5 pin held when toggle suppressed", int'(toggle_out), 0);
        repeat (2) @(negedge clk);
        chk("R7 reset at fine second expiry", int'(rst_req), 1);

        wr(5'h18, 8'h03);                  // lock
        wr(5'h18, 8'h00);                  // ignored
        wr(5'h10, 8'h08);                  // ignored
        chk("R10 control frozen", int'(rst_warm), 0);
        key(); wr(5'h0D, 8'h01);
        repeat (4) @(negedge clk);
        chk("R10 no reset yet", int'(rst_req), 0);
        @(negedge clk);
        chk("R10 locked timer still running", int'(rst_req), 1);
        repeat (5) @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule